// File: doc/BRIEF.md
# Prefixed Shift-Rotate Execution Unit

This unit runs the second byte of a two-byte prefixed 8-bit instruction family that rotates, shifts or nibble-swaps one byte. The opcode byte is presented with a start strobe. Its low three bits pick the operand, and bits 5:3 pick one of eight operations. The operand is either one of seven byte registers held inside the unit or the memory byte addressed by the H:L register pair. The unit writes the result back to where the operand came from and updates the flag byte.

Register operands finish in a single cycle. The memory operand runs as a read cycle, then a write cycle to the same address, then a done pulse. A small load port lets the surrounding core preset any register or the flag byte while the unit is idle. All eight storage bytes are brought out on one flat view bus.

Top module: `shrot_unit`

## Requirements
- R1: Opcode bits [2:0] pick the operand: 0=B, 1=C, 2=D, 3=E, 4=H, 5=L, 6=memory byte at address {H,L}, 7=A. The result goes back to that operand only. `rf_view[8*k+7:8*k]` shows the register with code k, and byte 6 of the view is the flag byte. Opcode bits [7:6] are ignored.
- R2: Opcode bits [5:3] pick the operation: 0=RLC, 1=RRC, 2=RL, 3=RR, 4=SLA, 5=SRA, 6=SWAP, 7=SRL.
- R3: RLC moves bit 7 into both carry and bit 0 (0x81 gives 0x03, carry 1). RRC moves bit 0 into both carry and bit 7 (0x81 gives 0xC0, carry 1).
- R4: RL shifts left, with the old carry entering bit 0 and bit 7 becoming the new carry. RR shifts right, with the old carry entering bit 7 and bit 0 becoming the new carry.
- R5: SLA shifts left, fills bit 0 with zero and puts bit 7 in carry. SRA shifts right, keeps bit 7 and puts bit 0 in carry (0x82 gives 0xC1). SRL shifts right, fills bit 7 with zero and puts bit 0 in carry (0x82 gives 0x41).
- R6: SWAP exchanges the two nibbles (0xAB gives 0xBA) and always clears carry.
- R7: The flag byte has Z at bit 7, N at bit 6, H at bit 5 and C at bit 4. Every operation sets Z exactly when the 8-bit result is 0x00, clears N and H, writes C as above, and leaves bits 3:0 unchanged.
- R8: A register operation accepted on a clock edge has its result and flags visible in the next cycle. `done` is high for that cycle and `busy` stays low.
- R9: A memory operation drives one cycle of `mem_rd` with `mem_addr` = {H,L}. It then drives one cycle of `mem_wr` with the same address and the result on `mem_wdata`. `done` follows in the next cycle, when the flags are updated.
- R10: Writing back H or L changes only that byte of the H:L pair, and all other storage keeps its value.
- R11: While `busy` is high, `start` and the load port are ignored.
- R12: After reset all storage bytes, including the flags, are 0x00, and `busy`, `done`, `mem_rd` and `mem_wr` are low.
- R13: When idle and not starting, `ld_en` writes `ld_data` to the byte with code `ld_sel` (code 6 = flag byte) on the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin executing `opcode` (taken when idle) |
| opcode | input | 8 | Second instruction byte |
| ld_en | input | 1 | Load strobe for a storage byte |
| ld_sel | input | 3 | Storage byte code for the load |
| ld_data | input | 8 | Load value |
| mem_rdata | input | 8 | Memory read data, valid during the `mem_rd` cycle |
| busy | output | 1 | Memory operation in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_rd | output | 1 | Memory read cycle |
| mem_wr | output | 1 | Memory write cycle |
| mem_addr | output | 16 | Memory address ({H,L}) |
| mem_wdata | output | 8 | Memory write data |
| rf_view | output | 64 | All eight storage bytes, indexed by operand code |

## Verification
The assertions check the handshake order on every cycle. A read cycle is always followed by a write to the same address, a write is followed by done with the unit idle again, and read and write never overlap. A register operation never goes busy. At each done, N and H are clear, Z agrees with the written memory byte, and SWAP leaves carry clear. The bench scenarios are needed for the data itself. They sweep every operation over all 256 operand values with both carry inputs, through every operand code and through memory. They also confirm that H and L write-back leaves the neighbour byte alone, and that strobes arriving mid-operation change nothing.

// File: rtl/shrot_pkg.sv
package shrot_pkg;
  localparam int DW    = 8;
  localparam int AW    = 2 * DW;
  localparam int NSEL  = 8;
  localparam int SELW  = $clog2(NSEL);
  localparam int VIEWW = NSEL * DW;

  localparam logic [SELW-1:0] SEL_MEM = 3'd6;
  localparam logic [SELW-1:0] SEL_H   = 3'd4;
  localparam logic [SELW-1:0] SEL_L   = 3'd5;

  localparam int FLG_Z = 7;
  localparam int FLG_N = 6;
  localparam int FLG_H = 5;
  localparam int FLG_C = 4;

  typedef enum logic [2:0] {
    OP_RLC, OP_RRC, OP_RL, OP_RR, OP_SLA, OP_SRA, OP_SWAP, OP_SRL
  } shrot_op_e;

  // returns {carry_out, result}
  function automatic logic [DW:0] shrot_calc(shrot_op_e op, logic [DW-1:0] v, logic cin);
    logic [DW:0] r;
    case (op)
      OP_RLC:  r = {v[DW-1], v[DW-2:0], v[DW-1]};
      OP_RRC:  r = {v[0], v[0], v[DW-1:1]};
      OP_RL:   r = {v[DW-1], v[DW-2:0], cin};
      OP_RR:   r = {v[0], cin, v[DW-1:1]};
      OP_SLA:  r = {v[DW-1], v[DW-2:0], 1'b0};
      OP_SRA:  r = {v[0], v[DW-1], v[DW-1:1]};
      OP_SWAP: r = {1'b0, v[DW/2-1:0], v[DW-1:DW/2]};
      default: r = {v[0], 1'b0, v[DW-1:1]};
    endcase
    return r;
  endfunction

  function automatic logic [DW-1:0] flag_merge(logic [DW-1:0] old, logic [DW-1:0] res, logic cout);
    logic [DW-1:0] f;
    f        = old;
    f[FLG_Z] = (res == '0);
    f[FLG_N] = 1'b0;
    f[FLG_H] = 1'b0;
    f[FLG_C] = cout;
    return f;
  endfunction
endpackage

// File: rtl/shrot_alu.sv
module shrot_alu
  import shrot_pkg::*;
(
  input  logic [2:0]    op,
  input  logic [DW-1:0] operand,
  input  logic          cin,
  output logic [DW-1:0] res,
  output logic          cout
);
  logic [DW:0] calc;
  always_comb begin
    calc = shrot_calc(shrot_op_e'(op), operand, cin);
    res  = calc[DW-1:0];
    cout = calc[DW];
  end
endmodule

// File: rtl/shrot_regfile.sv
module shrot_regfile
  import shrot_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_we,
  input  logic [SELW-1:0]  ld_sel,
  input  logic [DW-1:0]    ld_data,
  input  logic             res_we,
  input  logic [SELW-1:0]  res_sel,
  input  logic [DW-1:0]    res_data,
  input  logic             flag_we,
  input  logic [DW-1:0]    flag_data,
  output logic [VIEWW-1:0] view,
  output logic [AW-1:0]    hl,
  output logic             carry
);
  for (genvar i = 0; i < NSEL; i++) begin : g_ent
    logic [DW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  q <= '0;
      else if (flag_we && (SELW'(i) == SEL_MEM))   q <= flag_data;
      else if (res_we && (res_sel == SELW'(i)))    q <= res_data;
      else if (ld_we && (ld_sel == SELW'(i)))      q <= ld_data;
    end
    assign view[i*DW +: DW] = q;
  end

  assign hl    = {view[SEL_H*DW +: DW], view[SEL_L*DW +: DW]};
  assign carry = view[SEL_MEM*DW + FLG_C];
endmodule

// File: rtl/shrot_seq.sv
module shrot_seq
  import shrot_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [2:0]      op_in,
  input  logic [SELW-1:0] sel_in,
  input  logic [DW-1:0]   alu_res,
  input  logic            alu_cout,
  output logic            accept_reg,
  output logic            accept_mem,
  output logic            busy,
  output logic            in_rd,
  output logic            in_wr,
  output logic            done,
  output logic [2:0]      op_q,
  output logic [DW-1:0]   res_q,
  output logic            cout_q
);
  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} state_e;
  state_e state;

  assign busy       = (state != S_IDLE);
  assign in_rd      = (state == S_RD);
  assign in_wr      = (state == S_WR);
  assign accept_reg = start && !busy && (sel_in != SEL_MEM);
  assign accept_mem = start && !busy && (sel_in == SEL_MEM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      done   <= 1'b0;
      op_q   <= '0;
      res_q  <= '0;
      cout_q <= 1'b0;
    end else begin
      done <= accept_reg || in_wr;
      case (state)
        S_IDLE: if (accept_mem) begin
          state <= S_RD;
          op_q  <= op_in;
        end
        S_RD: begin
          res_q  <= alu_res;
          cout_q <= alu_cout;
          state  <= S_WR;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
  import shrot_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [7:0]  opcode,
  input  logic        ld_en,
  input  logic [2:0]  ld_sel,
  input  logic [7:0]  ld_data,
  input  logic [7:0]  mem_rdata,
  output logic        busy,
  output logic        done,
  output logic        mem_rd,
  output logic        mem_wr,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  output logic [63:0] rf_view
);
  logic [SELW-1:0] sel;
  logic [2:0]      op_fld, op_q, op_now;
  logic            accept_reg, accept_mem;
  logic [DW-1:0]   operand, alu_res, res_q, flag_q, flag_src, flag_next;
  logic            alu_cout, cout_q, carry, flag_cout;
  logic [AW-1:0]   hl;
  logic            unused_grp;

  assign sel        = opcode[2:0];
  assign op_fld     = opcode[5:3];
  assign unused_grp = ^opcode[7:6];

  shrot_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .op_in(op_fld), .sel_in(sel),
    .alu_res(alu_res), .alu_cout(alu_cout),
    .accept_reg(accept_reg), .accept_mem(accept_mem), .busy(busy),
    .in_rd(mem_rd), .in_wr(mem_wr), .done(done),
    .op_q(op_q), .res_q(res_q), .cout_q(cout_q)
  );

  assign op_now  = busy ? op_q : op_fld;
  assign operand = mem_rd ? mem_rdata : rf_view[{sel, 3'b000} +: DW];

  shrot_alu u_alu (
    .op(op_now), .operand(operand), .cin(carry), .res(alu_res), .cout(alu_cout)
  );

  assign flag_q    = rf_view[SEL_MEM*DW +: DW];
  assign flag_src  = accept_reg ? alu_res : res_q;
  assign flag_cout = accept_reg ? alu_cout : cout_q;
  assign flag_next = flag_merge(flag_q, flag_src, flag_cout);

  shrot_regfile u_rf (
    .clk(clk), .rst_n(rst_n),
    .ld_we(ld_en && !busy && !start), .ld_sel(ld_sel), .ld_data(ld_data),
    .res_we(accept_reg), .res_sel(sel), .res_data(alu_res),
    .flag_we(accept_reg || mem_wr), .flag_data(flag_next),
    .view(rf_view), .hl(hl), .carry(carry)
  );

  assign mem_addr  = hl;
  assign mem_wdata = res_q;
endmodule

// File: rtl/shrot_chk.sv
module shrot_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        mem_rd,
  input logic        mem_wr,
  input logic [15:0] mem_addr,
  input logic [7:0]  mem_wdata,
  input logic [7:0]  flag_q,
  input logic        accept_reg,
  input logic        accept_mem,
  input logic [2:0]  op_fld
);
  assert_mem_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept_mem |=> mem_rd && busy);
  assert_rd_to_wr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> mem_wr && !mem_rd && (mem_addr == $past(mem_addr)));
  assert_wr_to_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> done && !busy);
  assert_rd_wr_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  assert_reg_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept_reg |=> done && !busy && !mem_rd);
  assert_nh_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (flag_q[6:5] == 2'b00));
  assert_zero_mem_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> (flag_q[7] == ($past(mem_wdata) == 8'h00)));
  assert_swap_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_reg && (op_fld == 3'd6)) |=> !flag_q[4]);
endmodule

bind shrot_unit shrot_chk u_chk (.*);

// File: tb/tb_shrot_unit.sv
module tb_shrot_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic        ld_en = 1'b0;
  logic [2:0]  ld_sel = 3'd0;
  logic [7:0]  ld_data = 8'h00;
  logic [7:0]  mem_rdata = 8'h00;
  logic        busy, done, mem_rd, mem_wr;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [63:0] rf_view;

  int n_chk = 0;
  int n_fail = 0;
  int mdl [8];
  bit finished = 0;

  always #5 clk = ~clk;

  shrot_unit dut (.*);

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int expect_op(int op, int v, int cin);
    int r, c;
    case (op)
      0: begin r = ((v * 2) % 256) + (v / 128); c = v / 128; end
      1: begin r = (v / 2) + (v % 2) * 128;     c = v % 2;   end
      2: begin r = ((v * 2) % 256) + cin;       c = v / 128; end
      3: begin r = (v / 2) + cin * 128;         c = v % 2;   end
      4: begin r = (v * 2) % 256;               c = v / 128; end
      5: begin r = (v / 2) + (v / 128) * 128;   c = v % 2;   end
      6: begin r = (v % 16) * 16 + (v / 16);    c = 0;       end
      default: begin r = v / 2;                 c = v % 2;   end
    endcase
    return c * 256 + r;
  endfunction

  function automatic string op_req(int op);
    if (op <= 1) return "R3";
    if (op <= 3) return "R4";
    if (op == 6) return "R6";
    return "R5";
  endfunction

  function automatic int new_flags(int old, int r, int c);
    return (r == 0 ? 128 : 0) + c * 16 + (old % 16);
  endfunction

  function automatic logic [63:0] mdl_view();
    logic [63:0] v;
    for (int k = 0; k < 8; k++) v[k*8 +: 8] = mdl[k][7:0];
    return v;
  endfunction

  task automatic load(int sel, int val);
    @(negedge clk);
    ld_en = 1'b1; ld_sel = sel[2:0]; ld_data = val[7:0];
    @(negedge clk);
    ld_en = 1'b0;
    mdl[sel] = val;
  endtask

  // register operation; req names the requirement for the whole-view check
  task automatic run_reg(int op, int sel, string req);
    int e;
    e = expect_op(op, mdl[sel], (mdl[6] / 16) % 2);
    @(negedge clk);
    start = 1'b1; opcode = 8'(op * 8 + sel) | 8'hC0;
    @(negedge clk);
    start = 1'b0;
    mdl[sel] = e % 256;
    mdl[6]   = new_flags(mdl[6], e % 256, e / 256);
    chk(done && !busy, "R8", "done after one cycle", {busy, done}, 2'b01);
    chk(rf_view == mdl_view(), req, "storage view", rf_view, mdl_view());
  endtask

  task automatic run_mem(int op, int v, int cin, bit poke);
    int e, hl;
    load(4, 8'h40 + op);
    load(5, v);
    load(6, 8'hE0 + cin * 16 + (v % 16));
    hl = mdl[4] * 256 + mdl[5];
    e  = expect_op(op, v, cin);
    mem_rdata = v[7:0];
    @(negedge clk);
    start = 1'b1; opcode = 8'(op * 8 + 6);
    @(negedge clk);
    start = poke; opcode = 8'h00;
    chk(mem_rd && !mem_wr && busy, "R9", "read cycle", {mem_rd, mem_wr}, 2'b10);
    chk(mem_addr == hl[15:0], "R9", "read address", mem_addr, hl);
    @(negedge clk);
    start = 1'b0;
    if (poke) begin ld_en = 1'b1; ld_sel = 3'd7; ld_data = 8'h55; end
    chk(mem_wr && !mem_rd, "R9", "write cycle", {mem_rd, mem_wr}, 2'b01);
    chk(mem_addr == hl[15:0], "R9", "write address", mem_addr, hl);
    chk(mem_wdata == e[7:0], op_req(op), "memory result", mem_wdata, e % 256);
    @(negedge clk);
    ld_en = 1'b0;
    mdl[6] = new_flags(mdl[6], e % 256, e / 256);
    chk(done && !busy, "R9", "done after write", {busy, done}, 2'b01);
    chk(rf_view == mdl_view(), poke ? "R11" : "R7",
        "storage after memory op", rf_view, mdl_view());
  endtask

  initial begin
    for (int k = 0; k < 8; k++) mdl[k] = 0;
    #12;
    // R12: reset state
    chk(rf_view == 64'h0, "R12", "storage at reset", rf_view, 0);
    chk({busy, done, mem_rd, mem_wr} == 4'b0, "R12", "controls at reset",
        {busy, done, mem_rd, mem_wr}, 0);
    rst_n = 1'b1;

    // R13: preset every byte through the load port
    for (int k = 0; k < 8; k++) load(k, 8'h11 * (k + 1));
    chk(rf_view == mdl_view(), "R13", "loaded view", rf_view, mdl_view());

    // R2..R7: every operation, every value, both carry inputs, on A
    for (int op = 0; op < 8; op++)
      for (int v = 0; v < 256; v++)
        for (int cin = 0; cin < 2; cin++) begin
          int e;
          load(7, v);
          load(6, 8'hE0 + cin * 16 + (v % 16));
          e = expect_op(op, v, cin);
          run_reg(op, 7, op_req(op));
          chk(rf_view[63:56] == e[7:0], op_req(op), "A result", rf_view[63:56], e % 256);
          chk(rf_view[55:48] == 8'(new_flags(8'hE0 + cin * 16 + (v % 16), e % 256, e / 256)),
              "R7", "flag byte", rf_view[55:48],
              new_flags(8'hE0 + cin * 16 + (v % 16), e % 256, e / 256));
        end

    // R1, R10: each register code; H and L leave their neighbour alone
    for (int sel = 0; sel < 8; sel++) begin
      if (sel == 6) continue;
      for (int op = 0; op < 8; op++)
        for (int pat = 0; pat < 4; pat++) begin
          for (int k = 0; k < 8; k++)
            if (k != 6) load(k, (8'h5A + 8'h33 * k + 8'h81 * pat + op) % 256);
          run_reg(op, sel, (sel == 4 || sel == 5) ? "R10" : "R1");
        end
    end

    // R9: every operation on the memory operand, every value
    for (int op = 0; op < 8; op++)
      for (int v = 0; v < 256; v++)
        run_mem(op, v, (v / 3) % 2, 1'b0);

    // R11: start and load strobes during a memory operation change nothing
    for (int op = 0; op < 8; op++) run_mem(op, 8'h81, 1, 1'b1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule